// File: doc/BRIEF.md
# I2C-Programmed Configuration Register with Output Select

This block is an I2C target that holds a single 5-bit configuration word and presents it to the rest of the chip through a small output selector. The host writes the word with a one-byte write transfer and reads it back with a one-byte read transfer. The storage behaves like a slow nonvolatile cell. An accepted write is staged when the stop condition arrives. It lands in the register only after a fixed busy time, and the target ignores its own address during that time.

Four of the stored bits feed one side of a 4-bit two-way selector, whose other side is a set of four parallel inputs. The fifth bit drives a separate output through a hold stage. That stage is transparent while the select input is low and keeps its value while select is high. An override input forces every register-sourced output to zero while select is low. A write-protect input can block a write. It is sampled at the end of the acknowledge of the data byte that is captured.

Top module: `i2c_cfg_mux`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Either one seen in the middle of a byte ends the transfer, and the partial byte is never stored.
- R2: Only the 7-bit address 1001110 (byte 0x9C for a write, 0x9D for a read; R/W is bit 0, sent last) is acknowledged. The all-zero general call address and every other address get no acknowledge.
- R3: The acknowledge is SDA pulled low during the ninth SCL pulse. It is given for a matching address and for every data byte of a write transfer.
- R4: A read returns one byte equal to {3'b000, stored[4:0]}. Bit 4 is the hold-stage bit and bits 3:0 are selector bits D, C, B, A from MSB to LSB. The override and select inputs do not affect it.
- R5: A written byte whose bits 7:5 are not all zero is acknowledged but never stored.
- R6: Only the first valid byte of a transfer is captured. Later bytes in the same transfer are acknowledged and ignored.
- R7: Write-protect is sampled on the SCL falling edge that ends the acknowledge of the captured byte. If it is high there, nothing is written, whatever its level at the stop. If it is low there, the byte is written even if write-protect rises before the stop.
- R8: A captured byte is committed only by a stop. A repeated start before the stop discards it.
- R9: After a commit the register is busy for BUSY_CYCLES clock cycles. It keeps its old value until the end of that time, and the target does not acknowledge its address while busy.
- R10: Reset clears the register and all outputs to zero, and SDA is released.
- R11: With select low and override low, mux_out equals stored[3:0] and solo_out equals stored[4].
- R12: With select low and override high, mux_out and solo_out are zero.
- R13: With select high, mux_out equals alt_in. solo_out keeps the value it had at the rise of select, even if the register changes meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the I2C lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_pull_o | output | 1 | High pulls the SDA line low (open-drain drive) |
| wp_i | input | 1 | Write-protect, high blocks the write |
| ovr_i | input | 1 | Forces register-sourced outputs low when select is low |
| sel_i | input | 1 | Selector control: low picks the register, high picks alt_in |
| alt_in | input | 4 | Parallel alternative selector inputs |
| mux_out | output | 4 | Selector outputs D..A in bits 3..0 |
| solo_out | output | 1 | Non-selected register bit through the hold stage |

## Verification
The write path is swept over all 32 valid words. Each word is read back and seen on the outputs, which separates a correct data path from stuck or swapped bits. Bytes with each non-zero upper pattern, a mix of invalid, valid and trailing bytes, and write-protect changes on both sides of the acknowledge show which byte is captured and when protection is sampled. Wrong addresses, the general call, an address during busy, a stop mid-byte and a repeated start test the framing rules. A sweep of alt_in with select high, including a register write during that time, separates the selector path from the hold stage.

// File: rtl/cfgreg_pkg.sv
// Shared widths and the link state type for the configuration register block.
package cfgreg_pkg;
    localparam int REG_W  = 5;
    localparam int MUX_W  = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } link_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises SCL and SDA into the clock domain and reports clock edges
// and start/stop conditions as one-cycle pulses.
// Assumes the I2C lines are slow compared with clk (several clocks per phase).
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_now,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_last;
    logic              sda_last;
    logic              scl_now;

    // Synchroniser chains plus one stage of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_last <= 1'b1;
            sda_last <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_last <= scl_pipe[STAGES-1];
            sda_last <= sda_pipe[STAGES-1];
        end
    end

    // Edge and bus-condition decode from current and previous samples.
    always_comb begin
        scl_now   = scl_pipe[STAGES-1];
        sda_now   = sda_pipe[STAGES-1];
        scl_rise  = scl_now & ~scl_last;
        scl_fall  = ~scl_now & scl_last;
        start_det = scl_now & scl_last & sda_last & ~sda_now;
        stop_det  = scl_now & scl_last & ~sda_last & sda_now;
    end
endmodule

// File: rtl/i2c_link.sv
// I2C target protocol engine: address match, acknowledge, single-byte read,
// capture of the first valid written byte, write-protect sampling at the end
// of its acknowledge, and a commit pulse on stop.
// Assumes edge pulses from i2c_line_sync; wp_i is quasi-static.
module i2c_link
    import cfgreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1001110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_now,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             wp_i,
    input  logic             busy_i,
    input  logic [REG_W-1:0] reg_q,
    output logic             sda_pull,
    output logic             commit,
    output logic [REG_W-1:0] commit_data
);
    link_state_t       state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txb;
    logic [BYTE_W-1:0] tx_next;
    logic              got_valid;
    logic              pend;

    // Byte served on a read: upper bits zero, register below.
    always_comb tx_next = {{(BYTE_W-REG_W){1'b0}}, reg_q};

    // Protocol state machine; start and stop override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            shreg       <= '0;
            txb         <= '0;
            sda_pull    <= 1'b0;
            got_valid   <= 1'b0;
            pend        <= 1'b0;
            commit      <= 1'b0;
            commit_data <= '0;
        end else begin
            commit <= 1'b0;
            if (start_det) begin
                state     <= ST_ADDR;
                bit_cnt   <= '0;
                sda_pull  <= 1'b0;
                got_valid <= 1'b0;
                pend      <= 1'b0;
            end else if (stop_det) begin
                state     <= ST_IDLE;
                sda_pull  <= 1'b0;
                commit    <= pend;
                pend      <= 1'b0;
                got_valid <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_now};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == ST_WDATA) begin
                                state    <= ST_WACK;
                                sda_pull <= 1'b1;
                            end else if (shreg[7:1] == DEV_ADDR && !busy_i) begin
                                state    <= ST_AACK;
                                sda_pull <= 1'b1;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (shreg[0]) begin
                                state    <= ST_RDATA;
                                txb      <= tx_next;
                                sda_pull <= ~tx_next[BYTE_W-1];
                            end else begin
                                state    <= ST_WDATA;
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            state    <= ST_WDATA;
                            sda_pull <= 1'b0;
                            if (!got_valid && shreg[7:5] == 3'b000) begin
                                got_valid   <= 1'b1;
                                commit_data <= shreg[REG_W-1:0];
                                pend        <= ~wp_i;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                state    <= ST_RACK;
                                sda_pull <= 1'b0;
                            end else begin
                                sda_pull <= ~txb[3'd7 - bit_cnt[2:0]];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall) state <= ST_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/nv_store.sv
// Models the slow storage cell: a commit starts a busy countdown and the
// staged word replaces the register in the cycle the countdown ends.
// Assumes commits do not arrive while busy (the link is deaf then).
module nv_store
    import cfgreg_pkg::*;
#(
    parameter int BUSY_CYCLES = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [REG_W-1:0] commit_data,
    output logic             busy,
    output logic [REG_W-1:0] reg_q
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0]    remain;
    logic [REG_W-1:0] staged;

    // Busy countdown and end-of-write register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            staged <= '0;
            reg_q  <= '0;
        end else if (commit && remain == '0) begin
            remain <= CW'(BUSY_CYCLES);
            staged <= commit_data;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
            if (remain == CW'(1)) reg_q <= staged;
        end
    end

    // Busy while the countdown runs.
    always_comb busy = (remain != '0);
endmodule

// File: rtl/out_select.sv
// Output selector: register or parallel inputs on the four selector bits,
// override to zero, and a hold stage for the fifth bit that closes while
// select is high.
// Assumes sel_i is synchronous to clk.
module out_select
    import cfgreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             ovr_i,
    input  logic [REG_W-1:0] reg_q,
    input  logic [MUX_W-1:0] alt_in,
    output logic [MUX_W-1:0] mux_out,
    output logic             solo_out
);
    logic [REG_W-1:0] live;
    logic             hold;

    // Register-sourced value after override.
    always_comb live = ovr_i ? '0 : reg_q;

    // Hold stage tracks the live bit while select is low.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold <= 1'b0;
        else if (!sel_i) hold <= live[REG_W-1];
    end

    // Final output selection.
    always_comb begin
        mux_out  = sel_i ? alt_in : live[MUX_W-1:0];
        solo_out = sel_i ? hold   : live[REG_W-1];
    end
endmodule

// File: rtl/i2c_cfg_mux.sv
// Top level: I2C-programmed 5-bit configuration register feeding a 4-bit
// two-way selector and a held single output.
// Assumes scl_i/sda_i are the resolved bus levels seen at the pins.
module i2c_cfg_mux
    import cfgreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1001110,
    parameter int         BUSY_CYCLES = 2000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    input  logic             wp_i,
    input  logic             ovr_i,
    input  logic             sel_i,
    input  logic [MUX_W-1:0] alt_in,
    output logic [MUX_W-1:0] mux_out,
    output logic             solo_out
);
    logic             sda_now;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             busy;
    logic             commit;
    logic [REG_W-1:0] commit_data;
    logic [REG_W-1:0] reg_q;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_now   (sda_now),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_now     (sda_now),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .wp_i        (wp_i),
        .busy_i      (busy),
        .reg_q       (reg_q),
        .sda_pull    (sda_pull_o),
        .commit      (commit),
        .commit_data (commit_data)
    );

    nv_store #(.BUSY_CYCLES(BUSY_CYCLES)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_data (commit_data),
        .busy        (busy),
        .reg_q       (reg_q)
    );

    out_select u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel_i),
        .ovr_i    (ovr_i),
        .reg_q    (reg_q),
        .alt_in   (alt_in),
        .mux_out  (mux_out),
        .solo_out (solo_out)
    );
endmodule

// File: rtl/i2c_cfg_mux_chk.sv
// Property checker for i2c_cfg_mux, attached with bind below.
module i2c_cfg_mux_chk
    import cfgreg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sel_i,
    input logic             ovr_i,
    input logic [MUX_W-1:0] mux_out,
    input logic             solo_out,
    input logic             sda_pull_o,
    input logic             scl_fall,
    input logic             busy,
    input logic             commit,
    input logic [REG_W-1:0] reg_q
);
    // R9: the stored word only moves when the busy time ends.
    p_reg_moves_at_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_q) |-> $fell(busy));

    // R8: a busy period is only ever started by a commit from the link.
    p_busy_from_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit));

    // R12: override with select low clears register-sourced outputs.
    p_override_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i && ovr_i) |-> (mux_out == '0 && !solo_out));

    // R13: the held bit does not move while select stays high.
    p_solo_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && $past(sel_i)) |-> $stable(solo_out));

    // R3: SDA is only ever newly pulled right after an SCL falling edge.
    p_pull_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(scl_fall));
endmodule

bind i2c_cfg_mux i2c_cfg_mux_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .ovr_i      (ovr_i),
    .mux_out    (mux_out),
    .solo_out   (solo_out),
    .sda_pull_o (sda_pull_o),
    .scl_fall   (scl_fall),
    .busy       (busy),
    .commit     (commit),
    .reg_q      (reg_q)
);

// File: tb/i2c_cfg_mux_test.sv
module i2c_cfg_mux_test;
    localparam int BUSY = 400;
    localparam int Q    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic       ovr = 1'b0;
    logic       sel = 1'b0;
    logic [3:0] alt = 4'h0;
    logic       sda_pull;
    logic [3:0] mux_out;
    logic       solo_out;
    logic       sda_line;

    int vecs = 0;
    int bad  = 0;
    bit done = 0;

    logic       ack_a, ack_d, ack_x;
    logic [7:0] rdv;
    logic [4:0] exp_reg;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_cfg_mux #(.BUSY_CYCLES(BUSY)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .wp_i       (wp),
        .ovr_i      (ovr),
        .sel_i      (sel),
        .alt_in     (alt),
        .mux_out    (mux_out),
        .solo_out   (solo_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        vecs++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        acked = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            bit_in(x);
            b[i] = x;
        end
        bit_out(1'b1);
    endtask

    task automatic wr1(input logic [7:0] d, output logic aa, output logic ad);
        i2c_start();
        send_byte(8'h9C, aa);
        ad = 1'b0;
        if (aa) send_byte(d, ad);
        i2c_stop();
    endtask

    task automatic rd1(output logic [7:0] v, output logic aa);
        i2c_start();
        send_byte(8'h9D, aa);
        v = 8'hxx;
        if (aa) recv_byte(v);
        i2c_stop();
    endtask

    task automatic check_outs(input string req, input logic [4:0] v);
        chk(req, {27'd0, solo_out, mux_out}, {27'd0, v});
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R10: reset state
        check_outs("R10 outputs after reset", 5'h00);
        chk("R10 sda released", {31'd0, sda_pull}, 32'd0);
        rd1(rdv, ack_a);
        chk("R10 read after reset", {24'd0, rdv}, 32'd0);
        exp_reg = 5'h00;

        // R11/R4/R9/R3: sweep all valid words
        for (int v = 0; v < 32; v++) begin
            wr1({3'b000, 5'(v)}, ack_a, ack_d);
            chk("R3 address ack", {31'd0, ack_a}, 32'd1);
            chk("R3 data ack", {31'd0, ack_d}, 32'd1);
            check_outs("R9 old value while busy", exp_reg);
            if (v == 5) begin
                i2c_start();
                send_byte(8'h9C, ack_x);
                i2c_stop();
                chk("R9 no ack while busy", {31'd0, ack_x}, 32'd0);
            end
            tick(BUSY + 20);
            exp_reg = 5'(v);
            check_outs("R11 outputs follow register", exp_reg);
            rd1(rdv, ack_a);
            chk("R4 read back", {24'd0, rdv}, {27'd0, exp_reg});
        end

        // R5: invalid upper patterns acked, never stored
        for (int h = 1; h < 8; h++) begin
            wr1({3'(h), 5'b00110}, ack_a, ack_d);
            chk("R5 invalid byte acked", {31'd0, ack_d}, 32'd1);
        end
        tick(BUSY + 20);
        check_outs("R5 invalid not stored", exp_reg);

        // R6: first valid byte of a transfer wins
        i2c_start();
        send_byte(8'h9C, ack_a);
        send_byte(8'hA0, ack_d);
        send_byte(8'h0A, ack_d);
        send_byte(8'h13, ack_x);
        i2c_stop();
        chk("R6 trailing byte acked", {31'd0, ack_x}, 32'd1);
        tick(BUSY + 20);
        exp_reg = 5'h0A;
        check_outs("R6 first valid stored", exp_reg);

        // R7: write-protect high at the acknowledge blocks the write
        wp = 1'b1;
        wr1(8'h11, ack_a, ack_d);
        tick(BUSY + 20);
        check_outs("R7 protected write blocked", exp_reg);
        i2c_start();
        send_byte(8'h9C, ack_a);
        send_byte(8'h12, ack_d);
        wp = 1'b0;
        i2c_stop();
        tick(BUSY + 20);
        check_outs("R7 wp dropped after ack still blocked", exp_reg);
        i2c_start();
        send_byte(8'h9C, ack_a);
        send_byte(8'h07, ack_d);
        wp = 1'b1;
        i2c_stop();
        wp = 1'b0;
        tick(BUSY + 20);
        exp_reg = 5'h07;
        check_outs("R7 wp raised after ack still written", exp_reg);

        // R1: stop in the middle of a data byte
        i2c_start();
        send_byte(8'h9C, ack_a);
        bit_out(1'b0); bit_out(1'b0); bit_out(1'b0); bit_out(1'b1);
        i2c_stop();
        tick(BUSY + 20);
        check_outs("R1 partial byte discarded", exp_reg);

        // R8: repeated start before stop discards the captured byte
        i2c_start();
        send_byte(8'h9C, ack_a);
        send_byte(8'h01, ack_d);
        i2c_start();
        send_byte(8'h9E, ack_x);
        i2c_stop();
        tick(BUSY + 20);
        check_outs("R8 repeated start discards", exp_reg);

        // R2: wrong addresses and general call
        wr1(8'h03, ack_a, ack_d);
        chk("R2 own address acked", {31'd0, ack_a}, 32'd1);
        tick(BUSY + 20);
        exp_reg = 5'h03;
        foreach (rdv[i]) ; // no-op keeps loop variables local
        i2c_start(); send_byte(8'h9E, ack_x); i2c_stop();
        chk("R2 neighbour address nacked", {31'd0, ack_x}, 32'd0);
        i2c_start(); send_byte(8'h00, ack_x); i2c_stop();
        chk("R2 general call nacked", {31'd0, ack_x}, 32'd0);
        i2c_start(); send_byte(8'h1C, ack_x); i2c_stop();
        chk("R2 other address nacked", {31'd0, ack_x}, 32'd0);

        // R12: override clears outputs, read unaffected (R4)
        wr1(8'h1B, ack_a, ack_d);
        tick(BUSY + 20);
        exp_reg = 5'h1B;
        ovr = 1'b1;
        tick(2);
        check_outs("R12 override forces zero", 5'h00);
        rd1(rdv, ack_a);
        chk("R4 read ignores override", {24'd0, rdv}, 32'h1B);
        ovr = 1'b0;
        tick(2);
        check_outs("R11 outputs back after override", exp_reg);

        // R13: select high passes alt_in and holds solo_out
        sel = 1'b1;
        for (int a = 0; a < 16; a++) begin
            alt = 4'(a);
            tick(2);
            chk("R13 mux follows alt", {28'd0, mux_out}, a);
            chk("R13 solo held", {31'd0, solo_out}, 32'd1);
        end
        wr1(8'h05, ack_a, ack_d);
        tick(BUSY + 20);
        exp_reg = 5'h05;
        chk("R13 solo held across register write", {31'd0, solo_out}, 32'd1);
        sel = 1'b0;
        tick(2);
        check_outs("R11 register after select low", exp_reg);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        done = 1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end
endmodule